// File: doc/BRIEF.md
# Burst Line Fill Sequencer

The sequencer fetches one 16-byte line from an external memory that can burst. It cuts the line into bus beats and groups those beats into bursts. The split follows two inputs: the external data width (8, 16 or 32 bits) and a 2-bit grouping mode held in a small configuration register. The same register holds a 2-bit pacing value. That value sets how many idle cycles come before each beat that is not the first beat of its burst.

On the internal side, a request carries the line address. A one-cycle acknowledge reports that the assembled line is valid on the output. On the memory side, the block drives a beat strobe, the beat address and a burst-start mark, and it takes the read data in the beat cycle. A setting that has no pattern for the active width is refused: a one-cycle error pulse is raised and no memory beat is issued.

Top module: `burst_line_seq`

## Requirements
- R1: The configuration register reads 0 after reset. Pacing sits in bits [1:0] and grouping mode in bits [9:8]. Both fields can be written and read back, and every other bit reads 0.
- R2: Width code 00 selects an 8-bit bus. Mode 00 gives one burst of 16 beats. Mode 01 gives four bursts of 4 beats.
- R3: Width code 01 selects a 16-bit bus. Mode 00 gives one burst of 8 beats. Mode 01 gives four bursts of 2 beats.
- R4: On the 16-bit bus, mode 10 gives bursts of 4 and 4 beats when line address bit 2 is 0. It gives bursts of 2, 4 and 2 beats when that bit is 1.
- R5: Width code 10 selects a 32-bit bus. With mode 00, 01 or 10 it gives one burst of 4 beats, and the mode value has no effect.
- R6: The following combinations are illegal: mode 11 at any width, mode 10 on the 8-bit bus, and width code 11. An accepted request with one of them raises err for exactly the cycle after the request. It issues no beat and no acknowledge.
- R7: The pacing value P (0 to 3) puts exactly P idle cycles before every beat that is not the first beat of its burst. The first beat of a burst follows the previous beat with no gap. The first beat of a transfer comes in the cycle after the request is taken.
- R8: The first beat address is the line address aligned down to the beat size. Each further beat adds the beat size in bytes, and the low four address bits wrap inside the 16-byte line.
- R9: Line byte k sits at line_data[8k+7:8k]. A beat at line offset o writes its data lanes (mem_rdata byte 0 upward) to offsets o, o+1, and so on.
- R10: ack is high for exactly one cycle, in the cycle right after the last beat, and no beat is issued in that cycle. A request held high while a transfer runs starts no second transfer.
- R11: Width, mode, pacing and address are sampled when a request is taken. A configuration write in that same cycle takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| bus_width | input | 2 | External width code: 00 = 8, 01 = 16, 10 = 32 bits |
| req | input | 1 | Line fetch request, taken when idle |
| line_addr | input | 32 | Byte address inside the wanted line |
| ack | output | 1 | One-cycle line-valid pulse |
| err | output | 1 | One-cycle illegal-setting pulse |
| line_data | output | 128 | Assembled 16-byte line |
| beat_strobe | output | 1 | Memory beat in this cycle |
| burst_start | output | 1 | This beat opens a burst |
| beat_addr | output | 32 | Byte address of the current beat |
| mem_rdata | input | 32 | Memory read data, taken in the beat cycle |

## Verification
Two things can land in the same clock edge: taking a request, and a configuration write. The bench provokes this by raising req and cfg_we in the same cycle, with a pacing value that differs from the stored one. The beat gaps of that transfer must follow the old pacing, while the register reads back the new value and the next transfer uses it. A request held high across a whole transfer also meets the busy sequencer and the acknowledge cycle. This case is judged by a single acknowledge arriving at the expected cycle, with no beats after it.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int LINE_BYTES = 16;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int MAX_BEATS  = LINE_BYTES;
    localparam int NB_W       = $clog2(MAX_BEATS) + 1;
    localparam int PACE_LSB   = 0;
    localparam int MODE_LSB   = 8;

    typedef enum logic [1:0] {
        BW_8   = 2'b00,
        BW_16  = 2'b01,
        BW_32  = 2'b10,
        BW_BAD = 2'b11
    } bus_w_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BEAT,
        ST_WAIT,
        ST_DONE
    } seq_st_e;

    typedef struct packed {
        logic                  legal;
        logic [2:0]            bytes;
        logic [NB_W-1:0]       nbeats;
        logic [MAX_BEATS-1:0]  start_mask;
    } plan_t;

    // Bit i of start_mask set: beat i opens a new burst.
    function automatic plan_t make_plan(logic [1:0] width, logic [1:0] mode, logic odd_quad);
        plan_t p;
        p = '0;
        case (bus_w_e'(width))
            BW_8: begin
                p.bytes  = 3'd1;
                p.nbeats = NB_W'(16);
                case (mode)
                    2'b00: begin p.legal = 1'b1; p.start_mask = 16'h0001; end
                    2'b01: begin p.legal = 1'b1; p.start_mask = 16'h1111; end
                    default: p.legal = 1'b0;
                endcase
            end
            BW_16: begin
                p.bytes  = 3'd2;
                p.nbeats = NB_W'(8);
                case (mode)
                    2'b00: begin p.legal = 1'b1; p.start_mask = 16'h0001; end
                    2'b01: begin p.legal = 1'b1; p.start_mask = 16'h0055; end
                    2'b10: begin
                        p.legal      = 1'b1;
                        p.start_mask = odd_quad ? 16'h0045 : 16'h0011;
                    end
                    default: p.legal = 1'b0;
                endcase
            end
            BW_32: begin
                p.bytes      = 3'd4;
                p.nbeats     = NB_W'(4);
                p.start_mask = 16'h0001;
                p.legal      = (mode != 2'b11);
            end
            default: p.legal = 1'b0;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/bseq_cfg_reg.sv
module bseq_cfg_reg
    import burst_seq_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic [1:0]    mode,
    output logic [1:0]    pace
);
    logic [1:0] mode_q;
    logic [1:0] pace_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= 2'b00;
            pace_q <= 2'b00;
        end else if (we) begin
            mode_q <= wdata[MODE_LSB +: 2];
            pace_q <= wdata[PACE_LSB +: 2];
        end
    end

    always_comb begin
        rdata                = '0;
        rdata[MODE_LSB +: 2] = mode_q;
        rdata[PACE_LSB +: 2] = pace_q;
    end

    assign mode = mode_q;
    assign pace = pace_q;
endmodule

// File: rtl/bseq_plan.sv
module bseq_plan
    import burst_seq_pkg::*;
(
    input  logic [1:0] width,
    input  logic [1:0] mode,
    input  logic       odd_quad,
    output plan_t      plan
);
    assign plan = make_plan(width, mode, odd_quad);
endmodule

// File: rtl/bseq_line_asm.sv
module bseq_line_asm
    import burst_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [OFF_W-1:0]        off,
    input  logic [2:0]              bytes,
    input  logic [DW-1:0]           rdata,
    output logic [LINE_BYTES*8-1:0] line
);
    localparam int LANES  = DW / 8;
    localparam int LANE_W = $clog2(LANES);

    logic [7:0] lane [LANES];
    logic [7:0] buf_q [LINE_BYTES];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign lane[l] = rdata[8*l +: 8];
    end

    for (genvar k = 0; k < LINE_BYTES; k++) begin : g_byte
        logic [OFF_W-1:0] rel;
        logic             hit;
        assign rel = OFF_W'(k) - off;
        assign hit = wr_en && ({1'b0, rel} < (OFF_W+1)'(bytes));

        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q[k] <= 8'h00;
            end else if (hit) begin
                buf_q[k] <= lane[rel[LANE_W-1:0]];
            end
        end

        assign line[8*k +: 8] = buf_q[k];
    end
endmodule

// File: rtl/burst_line_seq.sv
module burst_line_seq
    import burst_seq_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CFG_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CFG_W-1:0]        cfg_wdata,
    output logic [CFG_W-1:0]        cfg_rdata,
    input  logic [1:0]              bus_width,
    input  logic                    req,
    input  logic [ADDR_W-1:0]       line_addr,
    output logic                    ack,
    output logic                    err,
    output logic [LINE_BYTES*8-1:0] line_data,
    output logic                    beat_strobe,
    output logic                    burst_start,
    output logic [ADDR_W-1:0]       beat_addr,
    input  logic [DATA_W-1:0]       mem_rdata
);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int IDX_W = $clog2(MAX_BEATS);

    logic [1:0] cfg_mode;
    logic [1:0] cfg_pace;
    plan_t      plan;

    seq_st_e              st_q;
    logic [MAX_BEATS-1:0] mask_q;
    logic [NB_W-1:0]      nbeats_q;
    logic [2:0]           bytes_q;
    logic [1:0]           pace_q;
    logic [1:0]           wcnt_q;
    logic [IDX_W-1:0]     idx_q;
    logic [TAG_W-1:0]     tag_q;
    logic [OFF_W-1:0]     off_q;
    logic                 err_q;

    logic [OFF_W-1:0] align_keep;
    logic [OFF_W-1:0] start_off;
    logic [IDX_W-1:0] next_idx;
    logic             last_beat;

    bseq_cfg_reg #(.CW(CFG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .mode  (cfg_mode),
        .pace  (cfg_pace)
    );

    bseq_plan u_plan (
        .width    (bus_width),
        .mode     (cfg_mode),
        .odd_quad (line_addr[2]),
        .plan     (plan)
    );

    assign align_keep = ~(OFF_W'(plan.bytes) - OFF_W'(1));
    assign start_off  = line_addr[OFF_W-1:0] & align_keep;
    assign next_idx   = idx_q + IDX_W'(1);
    assign last_beat  = (NB_W'(idx_q) == nbeats_q - NB_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            mask_q   <= '0;
            nbeats_q <= '0;
            bytes_q  <= '0;
            pace_q   <= '0;
            wcnt_q   <= '0;
            idx_q    <= '0;
            tag_q    <= '0;
            off_q    <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req) begin
                        if (!plan.legal) begin
                            err_q <= 1'b1;
                        end else begin
                            mask_q   <= plan.start_mask;
                            nbeats_q <= plan.nbeats;
                            bytes_q  <= plan.bytes;
                            pace_q   <= cfg_pace;
                            idx_q    <= '0;
                            tag_q    <= line_addr[ADDR_W-1:OFF_W];
                            off_q    <= start_off;
                            st_q     <= ST_BEAT;
                        end
                    end
                end
                ST_BEAT: begin
                    off_q <= off_q + OFF_W'(bytes_q);
                    idx_q <= next_idx;
                    if (last_beat) begin
                        st_q <= ST_DONE;
                    end else if (mask_q[next_idx] || pace_q == 2'd0) begin
                        st_q <= ST_BEAT;
                    end else begin
                        wcnt_q <= pace_q;
                        st_q   <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (wcnt_q == 2'd1) begin
                        st_q <= ST_BEAT;
                    end else begin
                        wcnt_q <= wcnt_q - 2'd1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign beat_strobe = (st_q == ST_BEAT);
    assign burst_start = beat_strobe && mask_q[idx_q];
    assign beat_addr   = {tag_q, off_q};
    assign ack         = (st_q == ST_DONE);
    assign err         = err_q;

    bseq_line_asm #(.DW(DATA_W)) u_asm (
        .clk   (clk),
        .rst   (rst),
        .wr_en (beat_strobe),
        .off   (off_q),
        .bytes (bytes_q),
        .rdata (mem_rdata),
        .line  (line_data)
    );
endmodule

// File: rtl/bseq_chk.sv
module bseq_chk #(
    parameter int AW = 32,
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst,
    input logic          ack,
    input logic          err,
    input logic          beat_strobe,
    input logic          burst_start,
    input logic [AW-1:0] beat_addr,
    input logic [1:0]    bus_width,
    input logic [CW-1:0] cfg_rdata
);
    localparam logic [CW-1:0] FIELD_BITS = CW'(32'h0000_0303);

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);

    // R10
    ack_no_beat_chk: assert property (@(posedge clk) disable iff (rst) ack |-> !beat_strobe);

    // R6
    err_quiet_chk: assert property (@(posedge clk) disable iff (rst) err |-> (!beat_strobe && !ack));

    // R6
    err_then_idle_chk: assert property (@(posedge clk) disable iff (rst) err |=> !beat_strobe);

    // R7
    start_on_beat_chk: assert property (@(posedge clk) disable iff (rst) burst_start |-> beat_strobe);

    // R1
    cfg_unused_zero_chk: assert property (@(posedge clk) disable iff (rst) (cfg_rdata & ~FIELD_BITS) == '0);

    // R8
    wide_align_chk: assert property (@(posedge clk) disable iff (rst)
        (beat_strobe && bus_width == 2'b10) |-> (beat_addr[1:0] == 2'b00));
endmodule

bind burst_line_seq bseq_chk #(.AW(ADDR_W), .CW(CFG_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .ack         (ack),
    .err         (err),
    .beat_strobe (beat_strobe),
    .burst_start (burst_start),
    .beat_addr   (beat_addr),
    .bus_width   (bus_width),
    .cfg_rdata   (cfg_rdata)
);

// File: tb/test_burst_line_seq.sv
module test_burst_line_seq;
    logic         clk = 1'b0;
    logic         rst;
    logic         cfg_we;
    logic [31:0]  cfg_wdata;
    logic [31:0]  cfg_rdata;
    logic [1:0]   bus_width;
    logic         req;
    logic [31:0]  line_addr;
    logic         ack;
    logic         err;
    logic [127:0] line_data;
    logic         beat_strobe;
    logic         burst_start;
    logic [31:0]  beat_addr;
    logic [31:0]  mem_rdata;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    burst_line_seq i_burst_line_seq (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .bus_width   (bus_width),
        .req         (req),
        .line_addr   (line_addr),
        .ack         (ack),
        .err         (err),
        .line_data   (line_data),
        .beat_strobe (beat_strobe),
        .burst_start (burst_start),
        .beat_addr   (beat_addr),
        .mem_rdata   (mem_rdata)
    );

    function automatic logic [7:0] pat(logic [31:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    always_comb begin
        mem_rdata = {pat(beat_addr + 32'd3), pat(beat_addr + 32'd2),
                     pat(beat_addr + 32'd1), pat(beat_addr)};
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic bit exp_start(logic [1:0] w, logic [1:0] m, bit a2, int i);
        if (w == 2'b00 && m == 2'b01) return (i % 4) == 0;
        if (w == 2'b01 && m == 2'b01) return (i % 2) == 0;
        if (w == 2'b01 && m == 2'b10) return a2 ? (i == 0 || i == 2 || i == 6) : ((i % 4) == 0);
        return i == 0;
    endfunction

    task automatic write_cfg(input logic [1:0] mode, input logic [1:0] pace);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = {22'd0, mode, 6'd0, pace};
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One legal transfer; mode/pace are the values expected to govern it.
    task automatic run_xfer(input string tag, input logic [1:0] w, input logic [1:0] mode,
                            input int pace, input logic [31:0] addr,
                            input bit hold_req, input bit clash, input logic [31:0] clash_val);
        int  bytes, nb, nbursts, exp_cyc, cyc, beats, last_cyc;
        bit  got_ack;
        logic [31:0] base;
        logic [3:0]  off;
        bytes = (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
        nb    = 16 / bytes;
        nbursts = 0;
        for (int i = 0; i < nb; i++) if (exp_start(w, mode, addr[2], i)) nbursts++;
        exp_cyc = nb + pace * (nb - nbursts) + 1;
        base = addr & ~32'hF;
        off  = addr[3:0] & ~4'(bytes - 1);
        cyc = 0; beats = 0; last_cyc = 0; got_ack = 1'b0;

        @(negedge clk);
        bus_width = w;
        line_addr = addr;
        req       = 1'b1;
        if (clash) begin
            cfg_we    = 1'b1;
            cfg_wdata = clash_val;
        end
        while (!got_ack && cyc < 400) begin
            @(negedge clk);
            cyc++;
            if (!hold_req) req = 1'b0;
            cfg_we = 1'b0;
            if (beat_strobe) begin
                chk(beat_addr == (base | 32'(off)), "R8", "beat address", beat_addr, base | 32'(off));
                chk(burst_start == exp_start(w, mode, addr[2], beats), tag, "burst start mark",
                    burst_start, exp_start(w, mode, addr[2], beats));
                if (beats > 0) begin
                    int gap;
                    gap = cyc - last_cyc - 1;
                    if (exp_start(w, mode, addr[2], beats))
                        chk(gap == 0, "R7", "gap before burst opener", gap, 0);
                    else
                        chk(gap == pace, "R7", "gap inside burst", gap, pace);
                end else begin
                    chk(cyc == 1, "R7", "first beat cycle", cyc, 1);
                end
                beats++;
                last_cyc = cyc;
                off = off + 4'(bytes);
            end
            if (ack) got_ack = 1'b1;
        end
        req = 1'b0;
        chk(beats == nb, tag, "beat count", beats, nb);
        chk(cyc == exp_cyc, "R10", "ack cycle", cyc, exp_cyc);
        for (int k = 0; k < 16; k++)
            chk(line_data[8*k +: 8] == pat(base + 32'(k)), "R9", "line byte",
                line_data[8*k +: 8], pat(base + 32'(k)));
        @(negedge clk);
        chk(!ack && !beat_strobe, "R10", "after ack", {ack, beat_strobe}, 0);
    endtask

    task automatic run_illegal(input logic [1:0] w, input logic [1:0] mode);
        write_cfg(mode, 2'd1);
        @(negedge clk);
        bus_width = w;
        line_addr = 32'h0000_0A40;
        req       = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(err && !beat_strobe && !ack, "R6", "error pulse", {err, beat_strobe, ack}, 3'b100);
        @(negedge clk);
        chk(!err && !beat_strobe && !ack, "R6", "after error", {err, beat_strobe, ack}, 0);
        @(negedge clk);
        chk(!beat_strobe && !ack, "R6", "no transfer", {beat_strobe, ack}, 0);
    endtask

    task automatic t_reset;
        chk(cfg_rdata == 32'd0, "R1", "cfg reset", cfg_rdata, 0);
        chk(!ack && !err && !beat_strobe, "R10", "reset outputs", {ack, err, beat_strobe}, 0);
    endtask

    task automatic t_cfg;
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        chk(cfg_rdata == 32'h0000_0303, "R1", "cfg all ones", cfg_rdata, 32'h303);
        write_cfg(2'b01, 2'b10);
        chk(cfg_rdata == 32'h0000_0102, "R1", "cfg fields", cfg_rdata, 32'h102);
    endtask

    task automatic t_eight;
        write_cfg(2'b00, 2'd0);
        run_xfer("R2", 2'b00, 2'b00, 0, 32'h0000_0100, 1'b0, 1'b0, 32'd0);
        write_cfg(2'b01, 2'd1);
        run_xfer("R2", 2'b00, 2'b01, 1, 32'h0000_0205, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_sixteen;
        write_cfg(2'b00, 2'd2);
        run_xfer("R3", 2'b01, 2'b00, 2, 32'h0000_030A, 1'b0, 1'b0, 32'd0);
        write_cfg(2'b01, 2'd3);
        run_xfer("R3", 2'b01, 2'b01, 3, 32'h0000_0400, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_split;
        write_cfg(2'b10, 2'd1);
        run_xfer("R4", 2'b01, 2'b10, 1, 32'h0000_0500, 1'b0, 1'b0, 32'd0);
        run_xfer("R4", 2'b01, 2'b10, 1, 32'h0000_051C, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_wide;
        write_cfg(2'b01, 2'd2);
        run_xfer("R5", 2'b10, 2'b01, 2, 32'h0000_0606, 1'b0, 1'b0, 32'd0);
        write_cfg(2'b10, 2'd3);
        run_xfer("R5", 2'b10, 2'b10, 3, 32'h0000_0708, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_illegal;
        run_illegal(2'b00, 2'b10);
        run_illegal(2'b01, 2'b11);
        run_illegal(2'b10, 2'b11);
        run_illegal(2'b11, 2'b00);
        write_cfg(2'b00, 2'd0);
        run_xfer("R6", 2'b10, 2'b00, 0, 32'h0000_0B00, 1'b0, 1'b0, 32'd0);
    endtask

    task automatic t_busy_hold;
        write_cfg(2'b01, 2'd1);
        run_xfer("R10", 2'b00, 2'b01, 1, 32'h0000_0C03, 1'b1, 1'b0, 32'd0);
    endtask

    task automatic t_clash;
        write_cfg(2'b00, 2'd0);
        run_xfer("R11", 2'b01, 2'b00, 0, 32'h0000_0D04, 1'b0, 1'b1, 32'h0000_0003);
        chk(cfg_rdata == 32'h0000_0003, "R11", "cfg after clash", cfg_rdata, 32'h3);
        run_xfer("R11", 2'b01, 2'b00, 3, 32'h0000_0E00, 1'b0, 1'b0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_we = 1'b0; cfg_wdata = '0;
        bus_width = 2'b00; req = 1'b0; line_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_eight();
        t_sixteen();
        t_split();
        t_wide();
        t_illegal();
        t_busy_hold();
        t_clash();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule